// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block is the control and status register that sits next to a floating-point unit. It holds the rounding-mode selection and the denormal-flush control that the datapath uses. It also keeps the exception state produced by each floating-point instruction. Per-instruction cause flags record what the most recent instruction raised. Sticky accumulation flags gather the exceptions that were masked. A read-only summary bit ORs together the serious masked exceptions.

Two sources update the register. The first is the completion side of the unit: a one-cycle strobe plus six raw exception indications for the instruction that just finished. The second is a software port used by move-to-control and pop-control operations, which writes the whole register in one cycle and reads it back combinationally. The block also raises a one-cycle trap request toward the CPU when an instruction raises an exception that is enabled, or raises the unimplemented-processing condition, which cannot be masked.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, sw_rdata reads 0, round_mode is 00 (round to nearest), flush_denorm is 0 and trap_req is 0.
- R2: Register bits [1:0] hold the rounding mode. It is written by software and driven on round_mode. The encodings are 00 nearest, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R3: On an instruction strobe without a software write, cause bits [7:2] are replaced by insn_exc[5:0] in the next cycle. The order, from bit 2 upward, is invalid, overflow, divide-by-zero, underflow, inexact, unimplemented. insn_exc uses the same order from bit 0.
- R4: A software write to a cause bit clears it when the written value is 0 and keeps its previous value when the written value is 1.
- R5: Register bit 8 is the denormal-flush control. It is written by software and driven on flush_denorm (1 means denormals are treated as zero).
- R6: Register bits [13:9] are the exception enables, written directly by software and in the same order as insn_exc[4:0]. An IEEE exception whose enable is 0 sets the matching accumulation bit in [18:14].
- R7: An exception whose enable is 1 leaves its accumulation bit unchanged. Accumulation bits stay at 1 until a software write loads them with 0.
- R8: Read-only bit 19 is the OR of the invalid, overflow, divide-by-zero and underflow accumulation bits (bits 14 to 17). The inexact accumulation bit (bit 18) does not affect it.
- R9: trap_req is high in the same cycle as insn_done exactly when an enabled IEEE exception or the unimplemented condition (insn_exc[5]) is raised.
- R10: When sw_wr and insn_done are both high in one cycle, the register takes the software write and discards the instruction's flag updates. trap_req is still produced from the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| insn_done | input | 1 | One-cycle strobe marking completion of an FPU instruction |
| insn_exc | input | 6 | Raw exception indications of the completing instruction |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 19 | Software write data for register bits [18:0] |
| sw_rdata | output | 20 | Current register contents, bit 19 being the summary |
| round_mode | output | 2 | Current rounding mode |
| flush_denorm | output | 1 | Denormal-to-zero control for the datapath |
| trap_req | output | 1 | Trap request to the CPU |

## Verification
A wrong cause or accumulation state appears on sw_rdata in the cycle right after the instruction strobe or write that produced it. The bench compares every field after every cycle, so the fault is reported on that edge. A wrong enable bit can stay hidden on the readback of the accumulation bits. It does show up on trap_req in the same cycle as the next strobe that carries that exception, because the trap logic and the masking logic share the enable.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int N_IEEE    = 5;
  localparam int N_CAUSE   = N_IEEE + 1;
  localparam int RM_LSB    = 0;
  localparam int CAUSE_LSB = 2;
  localparam int FLUSH_BIT = CAUSE_LSB + N_CAUSE;
  localparam int EN_LSB    = FLUSH_BIT + 1;
  localparam int ACC_LSB   = EN_LSB + N_IEEE;
  localparam int SUM_BIT   = ACC_LSB + N_IEEE;
  localparam int WR_W      = SUM_BIT;
  localparam int RD_W      = SUM_BIT + 1;
  localparam int SUM_SRC_W = 4;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS_INF = 2'b10,
    RM_NEG_INF = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpsr_cause.sv
module fpsr_cause #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wmask,
  input  logic         load,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cause
);
  logic [W-1:0] cause_d, cause_q;
  logic         cause_ce;

  always_comb begin
    cause_ce = wr | load;
    if (wr)        cause_d = cause_q & wmask;
    else if (load) cause_d = raw;
    else           cause_d = cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_ce) cause_q <= cause_d;
  end

  assign cause = cause_q;
endmodule

// File: rtl/fpsr_sticky.sv
module fpsr_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wen,
  input  logic [W-1:0] wacc,
  input  logic         load,
  input  logic [W-1:0] raw,
  output logic [W-1:0] enable,
  output logic [W-1:0] acc
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic en_q, acc_q, acc_d, acc_ce;

    always_comb begin
      acc_ce = wr | (load & raw[i] & ~en_q);
      acc_d  = wr ? wacc[i] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= 1'b0;
      else if (wr) en_q <= wen[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= 1'b0;
      else if (acc_ce) acc_q <= acc_d;
    end

    assign enable[i] = en_q;
    assign acc[i]    = acc_q;
  end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_done,
  input  logic [N_CAUSE-1:0] insn_exc,
  input  logic            sw_wr,
  input  logic [WR_W-1:0] sw_wdata,
  output logic [RD_W-1:0] sw_rdata,
  output logic [1:0]      round_mode,
  output logic            flush_denorm,
  output logic            trap_req
);
  logic [1:0]         rst_sync_q;
  logic               rst_i;
  rmode_e             rm_q, rm_d;
  logic               fl_q, fl_d;
  logic [N_CAUSE-1:0] cause;
  logic [N_IEEE-1:0]  enable, acc;
  logic               load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign load = insn_done & ~sw_wr;

  always_comb begin
    rm_d = rmode_e'(sw_wdata[RM_LSB +: 2]);
    fl_d = sw_wdata[FLUSH_BIT];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rm_q <= RM_NEAREST;
      fl_q <= 1'b0;
    end else if (sw_wr) begin
      rm_q <= rm_d;
      fl_q <= fl_d;
    end
  end

  fpsr_cause #(.W(N_CAUSE)) u_cause (
    .clk   (clk),
    .rst_n (rst_i),
    .wr    (sw_wr),
    .wmask (sw_wdata[CAUSE_LSB +: N_CAUSE]),
    .load  (load),
    .raw   (insn_exc),
    .cause (cause)
  );

  fpsr_sticky #(.W(N_IEEE)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_i),
    .wr     (sw_wr),
    .wen    (sw_wdata[EN_LSB +: N_IEEE]),
    .wacc   (sw_wdata[ACC_LSB +: N_IEEE]),
    .load   (load),
    .raw    (insn_exc[N_IEEE-1:0]),
    .enable (enable),
    .acc    (acc)
  );

  always_comb begin
    sw_rdata                        = '0;
    sw_rdata[RM_LSB +: 2]           = rm_q;
    sw_rdata[CAUSE_LSB +: N_CAUSE]  = cause;
    sw_rdata[FLUSH_BIT]             = fl_q;
    sw_rdata[EN_LSB +: N_IEEE]      = enable;
    sw_rdata[ACC_LSB +: N_IEEE]     = acc;
    sw_rdata[SUM_BIT]               = |acc[SUM_SRC_W-1:0];
  end

  assign round_mode   = rm_q;
  assign flush_denorm = fl_q;
  assign trap_req     = insn_done & rst_i &
                        ((|(insn_exc[N_IEEE-1:0] & enable)) | insn_exc[N_CAUSE-1]);
endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk
  import fpsr_pkg::*;
(
  input logic            clk,
  input logic            rst_ok,
  input logic            insn_done,
  input logic [N_CAUSE-1:0] insn_exc,
  input logic            sw_wr,
  input logic [WR_W-1:0] sw_wdata,
  input logic [RD_W-1:0] sw_rdata,
  input logic            trap_req
);
  p_cause_load_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    insn_done && !sw_wr |=> sw_rdata[CAUSE_LSB +: N_CAUSE] == $past(insn_exc));

  p_cause_write_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    sw_wr |=> sw_rdata[CAUSE_LSB +: N_CAUSE] ==
              ($past(sw_rdata[CAUSE_LSB +: N_CAUSE]) & $past(sw_wdata[CAUSE_LSB +: N_CAUSE])));

  p_masked_sets_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    insn_done && !sw_wr && insn_exc[0] && !sw_rdata[EN_LSB] |=> sw_rdata[ACC_LSB]);

  p_acc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !sw_wr |=> (sw_rdata[ACC_LSB +: N_IEEE] & $past(sw_rdata[ACC_LSB +: N_IEEE])) ==
               $past(sw_rdata[ACC_LSB +: N_IEEE]));

  p_summary_src_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    sw_rdata[SUM_BIT] |-> |sw_rdata[ACC_LSB +: SUM_SRC_W]);

  p_trap_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    trap_req |-> insn_done);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    sw_wr && insn_done |=> sw_rdata[ACC_LSB +: N_IEEE] == $past(sw_wdata[ACC_LSB +: N_IEEE]));
endmodule

bind fp_status_ctrl fp_status_ctrl_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_i),
  .insn_done (insn_done),
  .insn_exc  (insn_exc),
  .sw_wr     (sw_wr),
  .sw_wdata  (sw_wdata),
  .sw_rdata  (sw_rdata),
  .trap_req  (trap_req)
);

// File: tb/fp_status_ctrl_bench.sv
module fp_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_done;
  logic [5:0]  insn_exc;
  logic        sw_wr;
  logic [18:0] sw_wdata;
  logic [19:0] sw_rdata;
  logic [1:0]  round_mode;
  logic        flush_denorm;
  logic        trap_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [1:0] m_rm;
  logic       m_fl;
  logic [5:0] m_cause;
  logic [4:0] m_en, m_acc;

  always #2 clk = ~clk;

  fp_status_ctrl u_fp_status_ctrl (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .insn_exc(insn_exc),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .round_mode(round_mode), .flush_denorm(flush_denorm), .trap_req(trap_req)
  );

  function automatic logic [19:0] exp_rd();
    return {|m_acc[3:0], m_acc, m_en, m_fl, m_cause, m_rm};
  endfunction

  function automatic logic exp_trap(logic d, logic [5:0] e);
    return d & ((|(e[4:0] & m_en)) | e[5]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [19:0] e;
    e = exp_rd();
    check(sw_wr ? "R4" : "R3", 32'(sw_rdata[7:2]), 32'(e[7:2]));
    check("R2", 32'(round_mode), 32'(m_rm));
    check("R2", 32'(sw_rdata[1:0]), 32'(e[1:0]));
    check("R5", 32'(flush_denorm), 32'(m_fl));
    check("R6", 32'(sw_rdata[13:9]), 32'(e[13:9]));
    check("R7", 32'(sw_rdata[18:14]), 32'(e[18:14]));
    check("R8", 32'(sw_rdata[19]), 32'(e[19]));
  endtask

  task automatic step(logic wr, logic [18:0] wd, logic d, logic [5:0] e);
    @(negedge clk);
    sw_wr = wr; sw_wdata = wd; insn_done = d; insn_exc = e;
    #1;
    check(wr && d ? "R10" : "R9", 32'(trap_req), 32'(exp_trap(d, e)));
    @(posedge clk);
    #1;
    if (wr) begin
      m_rm = wd[1:0]; m_fl = wd[8]; m_en = wd[13:9]; m_acc = wd[18:14];
      m_cause = m_cause & wd[7:2];
    end else if (d) begin
      m_cause = e;
      m_acc = m_acc | (e[4:0] & ~m_en);
    end
    check_all();
    sw_wr = 1'b0; insn_done = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; insn_done = 1'b0; insn_exc = '0; sw_wr = 1'b0; sw_wdata = '0;
    m_rm = '0; m_fl = 1'b0; m_cause = '0; m_en = '0; m_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(sw_rdata), 32'h0);
    check("R1", 32'(round_mode), 32'h0);
    check("R1", 32'(flush_denorm), 32'h0);
    check("R1", 32'(trap_req), 32'h0);

    // R2 every rounding mode
    for (int m = 0; m < 4; m++) step(1'b1, 19'(m), 1'b0, '0);
    // R5 flush on
    step(1'b1, 19'h100, 1'b0, '0);
    // R3 instruction loads all causes, all masked -> R6 accumulate, R8 summary
    step(1'b0, '0, 1'b1, 6'h3F);
    // R4 write ones keeps causes, zeros clear half
    step(1'b1, {5'h1F, 5'h00, 1'b0, 6'h3F, 2'b00}, 1'b0, '0);
    step(1'b1, {5'h1F, 5'h00, 1'b0, 6'h15, 2'b00}, 1'b0, '0);
    // R8 only inexact accumulated -> summary 0
    step(1'b1, {5'h10, 5'h00, 1'b0, 6'h00, 2'b00}, 1'b0, '0);
    check("R8", 32'(sw_rdata[19]), 32'h0);
    // R7 enabled exceptions leave accumulation alone, R9 trap
    step(1'b1, {5'h00, 5'h1F, 1'b0, 6'h00, 2'b00}, 1'b0, '0);
    step(1'b0, '0, 1'b1, 6'h1F);
    // R9 unimplemented traps even with all enables off
    step(1'b1, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, 6'h20);
    // R10 collision: write wins
    step(1'b1, {5'h00, 5'h01, 1'b0, 6'h3F, 2'b10}, 1'b1, 6'h1F);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] == 4'd0, 19'($urandom), r[4] | r[5],
           6'($urandom) & 6'($urandom));
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule